// File: doc/BRIEF.md
# Encoder Edge Period Timer

This block measures time between encoder phase transitions. It is meant for low speeds, where too few position counts arrive in a sample window to give a useful velocity. A selectable power-of-two prescaler sets the timebase. An edge-age timer counts prescaled ticks since the most recent phase edge. A period counter runs next to it, and its value is copied into a buffer register whenever an edge arrives.

When the position-difference sample is taken, software or a neighbouring block pulses a read strobe. On that strobe the current edge age and the buffered period are copied into a pair of hold registers, so both values belong to the same instant. At the same time the period counter is reloaded from the edge age. This gives a velocity estimate from the time elapsed since the last edge and from the length of the last full interval. Both counters saturate at all ones instead of wrapping, so a stalled shaft reads as "very slow" and never as a small, wrong number.

Top module: `edge_period_timer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every output reads 0.
- R2: With prescaler select n, the two counters advance once per 2^n enabled clock cycles. The first advance comes on the 2^n-th rising edge after meas_en goes high.
- R3: A clock edge with phase_edge high and meas_en high sets edge_age to 0, and it counts from 0 again on later ticks.
- R4: edge_age stops at 0xFFFF and holds that value until a phase edge arrives.
- R5: A phase edge loads period_buf with the period_cnt value from before that clock edge.
- R6: A read strobe with meas_en high loads period_cnt with the edge_age value from before that clock edge.
- R7: A read strobe with meas_en high loads hold_age with edge_age and hold_period with period_buf, both taken from before that clock edge.
- R8: period_cnt stops at 0xFFFF. A phase edge that arrives while it is stopped there, with no read strobe in the same cycle, restarts it from 0.
- R9: While meas_en is low, edge_age, period_cnt and period_buf are 0. Phase edges and read strobes have no effect, and hold_age and hold_period keep their values.
- R10: If a phase edge and a read strobe arrive in the same cycle, hold_age, hold_period and period_cnt take their pre-edge sources. period_cnt takes the old edge_age, and edge_age still restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| meas_en | input | 1 | Measurement enable; low clears the counters and blocks captures |
| presc_sel | input | 4 | Prescaler select n, division by 2^n |
| phase_edge | input | 1 | Single-cycle strobe, a transition on either encoder phase |
| rd_strobe | input | 1 | Single-cycle strobe, position-difference sample taken |
| edge_age | output | 16 | Live ticks since the last phase edge (saturating) |
| period_cnt | output | 16 | Live period counter (saturating) |
| period_buf | output | 16 | Period counter value captured at the last phase edge |
| hold_age | output | 16 | edge_age captured at the last read strobe |
| hold_period | output | 16 | period_buf captured at the last read strobe |

## Verification
A wrong prescaler phase shows up at edge_age within 2^n cycles of enable, as a count that arrives early or late. A wrong capture ordering shows up in the first clock after a strobe: hold_period shows the new buffer instead of the old one, or period_cnt picks up a post-edge age of 0. Saturation faults surface only after 65535 ticks, as a wrap to 0 or as a counter that does not restart after the next edge. The bench therefore drives one long run with no division for that case.

// File: rtl/edge_period_timer_pkg.sv
// Package: shared widths for the edge period timer.
// Assumes: counter width and prescaler select width are chosen together here.
package edge_period_timer_pkg;
    localparam int unsigned CNT_W  = 16;
    localparam int unsigned PSEL_W = 4;
    // Divider counter must span the largest division 2^(2^PSEL_W - 1).
    localparam int unsigned PDIV_W = (1 << PSEL_W) - 1;
endpackage

// File: rtl/ept_prescaler.sv
// Module: ept_prescaler
// Produces a one-cycle tick every 2^sel enabled clocks.
// Assumes: the divider restarts from 0 while enable is low, so the first
// tick after enable comes on the 2^sel-th clock edge.
module ept_prescaler #(
    parameter int unsigned PSEL_W = 4,
    localparam int unsigned PDIV_W = (1 << PSEL_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [PSEL_W-1:0] sel,
    output logic              tick
);
    logic [PDIV_W-1:0] div_q;
    logic [PDIV_W-1:0] div_mask;

    // Free-running divider, cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Low sel bits of the divider, all ones once per 2^sel cycles.
    always_comb begin
        div_mask = ~({PDIV_W{1'b1}} << sel);
        tick     = enable && ((div_q & div_mask) == div_mask);
    end
endmodule

// File: rtl/ept_sat_counter.sv
// Module: ept_sat_counter
// Saturating up-counter with synchronous clear and parallel load.
// Assumes: priority is clear, then load, then increment; incrementing
// stops at all ones.
module ept_sat_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         at_max
);
    localparam logic [W-1:0] MAX_V = {W{1'b1}};

    // Counter update with the priority stated above.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (inc && (cnt != MAX_V)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Saturation indicator for the controlling logic.
    always_comb at_max = (cnt == MAX_V);
endmodule

// File: rtl/ept_capture_reg.sv
// Module: ept_capture_reg
// Plain capture register with synchronous clear and load strobe.
// Assumes: clear wins over load.
module ept_capture_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture on load, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (ld) begin
            q <= d;
        end
    end
endmodule

// File: rtl/edge_period_timer.sv
// Module: edge_period_timer
// Edge-age timer, period counter, edge buffer and read-strobe hold pair
// for low-speed encoder velocity measurement.
// Assumes: phase_edge and rd_strobe are single-cycle strobes already in
// the clk domain; all captures sample register outputs, so a coincident
// edge and read see pre-edge values.
module edge_period_timer
    import edge_period_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meas_en,
    input  logic [PSEL_W-1:0] presc_sel,
    input  logic              phase_edge,
    input  logic              rd_strobe,
    output logic [CNT_W-1:0]  edge_age,
    output logic [CNT_W-1:0]  period_cnt,
    output logic [CNT_W-1:0]  period_buf,
    output logic [CNT_W-1:0]  hold_age,
    output logic [CNT_W-1:0]  hold_period
);
    logic tick;
    logic age_max;
    logic per_max;
    logic edge_ev;
    logic rd_ev;
    logic per_clr;

    // Qualified events: nothing acts while measurement is disabled.
    always_comb begin
        edge_ev = meas_en && phase_edge;
        rd_ev   = meas_en && rd_strobe;
        per_clr = !meas_en || (edge_ev && per_max && !rd_ev);
    end

    ept_prescaler #(.PSEL_W(PSEL_W)) presc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (meas_en),
        .sel    (presc_sel),
        .tick   (tick)
    );

    ept_sat_counter #(.W(CNT_W)) age_ctr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!meas_en || edge_ev),
        .ld     (1'b0),
        .ld_val ('0),
        .inc    (tick),
        .cnt    (edge_age),
        .at_max (age_max)
    );

    ept_sat_counter #(.W(CNT_W)) per_ctr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (per_clr),
        .ld     (rd_ev),
        .ld_val (edge_age),
        .inc    (tick),
        .cnt    (period_cnt),
        .at_max (per_max)
    );

    ept_capture_reg #(.W(CNT_W)) buf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!meas_en),
        .ld    (edge_ev),
        .d     (period_cnt),
        .q     (period_buf)
    );

    ept_capture_reg #(.W(CNT_W)) hold_age_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (1'b0),
        .ld    (rd_ev),
        .d     (edge_age),
        .q     (hold_age)
    );

    ept_capture_reg #(.W(CNT_W)) hold_per_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (1'b0),
        .ld    (rd_ev),
        .d     (period_buf),
        .q     (hold_period)
    );

    logic unused_age_max;
    always_comb unused_age_max = age_max;
endmodule

// File: rtl/edge_period_timer_chk.sv
// Module: edge_period_timer_chk
// Port-level temporal checks for edge_period_timer, attached by bind.
module edge_period_timer_chk
    import edge_period_timer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              meas_en,
    input logic              phase_edge,
    input logic              rd_strobe,
    input logic [CNT_W-1:0]  edge_age,
    input logic [CNT_W-1:0]  period_cnt,
    input logic [CNT_W-1:0]  period_buf,
    input logic [CNT_W-1:0]  hold_age,
    input logic [CNT_W-1:0]  hold_period
);
    localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};

    a_r3_edge_clears_age: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_en && phase_edge) |=> (edge_age == '0));

    a_r4_age_stays_max: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_en && !phase_edge && edge_age == MAX_V) |=> (edge_age == MAX_V));

    a_r5_buf_takes_period: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_en && phase_edge) |=> (period_buf == $past(period_cnt)));

    a_r6_period_loads_age: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_en && rd_strobe) |=> (period_cnt == $past(edge_age)));

    a_r7_hold_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_en && rd_strobe) |=>
        (hold_age == $past(edge_age) && hold_period == $past(period_buf)));

    a_r8_period_stays_max: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_en && !phase_edge && !rd_strobe && period_cnt == MAX_V) |=>
        (period_cnt == MAX_V));

    a_r9_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_en |=> (edge_age == '0 && period_cnt == '0 && period_buf == '0));

    a_r9_holds_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!meas_en && $past(rst_n)) |=> ($stable(hold_age) && $stable(hold_period)));
endmodule

bind edge_period_timer edge_period_timer_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .meas_en     (meas_en),
    .phase_edge  (phase_edge),
    .rd_strobe   (rd_strobe),
    .edge_age    (edge_age),
    .period_cnt  (period_cnt),
    .period_buf  (period_buf),
    .hold_age    (hold_age),
    .hold_period (hold_period)
);

// File: tb/edge_period_timer_tb_top.sv
`timescale 1ns/1ps
module edge_period_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        meas_en = 1'b0;
    logic [3:0]  presc_sel = '0;
    logic        phase_edge = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [15:0] edge_age, period_cnt, period_buf, hold_age, hold_period;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    edge_period_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .meas_en     (meas_en),
        .presc_sel   (presc_sel),
        .phase_edge  (phase_edge),
        .rd_strobe   (rd_strobe),
        .edge_age    (edge_age),
        .period_cnt  (period_cnt),
        .period_buf  (period_buf),
        .hold_age    (hold_age),
        .hold_period (hold_period)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Disable for one cycle, set the division, re-enable at a negedge.
    task automatic restart(input logic [3:0] sel);
        meas_en = 1'b0;
        wait_cyc(1);
        presc_sel = sel;
        meas_en = 1'b1;
    endtask

    task automatic pulse(input logic e, input logic r);
        phase_edge = e;
        rd_strobe  = r;
        wait_cyc(1);
        phase_edge = 1'b0;
        rd_strobe  = 1'b0;
    endtask

    task automatic t_reset();
        meas_en = 1'b1;
        wait_cyc(3);
        check("R1", "edge_age", edge_age, 16'd0);
        check("R1", "period_cnt", period_cnt, 16'd0);
        check("R1", "period_buf", period_buf, 16'd0);
        check("R1", "hold_age", hold_age, 16'd0);
        check("R1", "hold_period", hold_period, 16'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_prescale();
        restart(4'd2);
        wait_cyc(3);
        check("R2", "sel2 after 3", edge_age, 16'd0);
        wait_cyc(1);
        check("R2", "sel2 after 4", edge_age, 16'd1);
        wait_cyc(4);
        check("R2", "sel2 after 8", edge_age, 16'd2);
        check("R2", "sel2 period", period_cnt, 16'd2);
        restart(4'd5);
        wait_cyc(31);
        check("R2", "sel5 after 31", edge_age, 16'd0);
        wait_cyc(1);
        check("R2", "sel5 after 32", edge_age, 16'd1);
    endtask

    task automatic t_edge_read();
        restart(4'd0);
        wait_cyc(10);
        check("R2", "sel0 after 10", edge_age, 16'd10);
        pulse(1'b1, 1'b0);
        check("R3", "age after edge", edge_age, 16'd0);
        check("R5", "buf after edge", period_buf, 16'd10);
        check("R8", "period not cleared when not saturated", period_cnt, 16'd11);
        wait_cyc(3);
        check("R3", "age counts again", edge_age, 16'd3);
        pulse(1'b0, 1'b1);
        check("R6", "period loaded", period_cnt, 16'd3);
        check("R7", "hold_age", hold_age, 16'd3);
        check("R7", "hold_period", hold_period, 16'd10);
        check("R7", "age keeps counting", edge_age, 16'd4);
        wait_cyc(1);
        check("R6", "period counts from load", period_cnt, 16'd4);
    endtask

    task automatic t_same_cycle();
        restart(4'd0);
        wait_cyc(6);
        pulse(1'b1, 1'b0);
        wait_cyc(4);
        check("R10", "pre age", edge_age, 16'd4);
        check("R10", "pre period", period_cnt, 16'd11);
        pulse(1'b1, 1'b1);
        check("R10", "hold_age pre-edge", hold_age, 16'd4);
        check("R10", "hold_period pre-edge", hold_period, 16'd6);
        check("R10", "period from old age", period_cnt, 16'd4);
        check("R10", "age restarted", edge_age, 16'd0);
        check("R10", "buf took period", period_buf, 16'd11);
    endtask

    task automatic t_disabled();
        meas_en = 1'b0;
        wait_cyc(2);
        check("R9", "age zero", edge_age, 16'd0);
        check("R9", "period zero", period_cnt, 16'd0);
        check("R9", "buf zero", period_buf, 16'd0);
        pulse(1'b1, 1'b1);
        wait_cyc(1);
        check("R9", "hold_age kept", hold_age, 16'd4);
        check("R9", "hold_period kept", hold_period, 16'd6);
        check("R9", "period ignores read", period_cnt, 16'd0);
        check("R9", "buf ignores edge", period_buf, 16'd0);
    endtask

    task automatic t_saturate();
        restart(4'd0);
        wait_cyc(65540);
        check("R4", "age saturated", edge_age, 16'hFFFF);
        check("R8", "period saturated", period_cnt, 16'hFFFF);
        wait_cyc(10);
        check("R4", "age still saturated", edge_age, 16'hFFFF);
        pulse(1'b1, 1'b0);
        check("R4", "age restarts", edge_age, 16'd0);
        check("R8", "period restarts", period_cnt, 16'd0);
        check("R5", "buf saturated value", period_buf, 16'hFFFF);
        wait_cyc(5);
        check("R4", "age resumes", edge_age, 16'd5);
        check("R8", "period resumes", period_cnt, 16'd5);
    endtask

    initial begin
        #(190000 * 5);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        wait_cyc(1);
        t_reset();
        t_prescale();
        t_edge_read();
        t_same_cycle();
        t_disabled();
        t_saturate();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule